// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Timer Channel

This block is one channel of an event timer. It keeps a 32-bit target and a 32-bit period, watches a free-running main counter supplied from outside, and raises a single-cycle `fire` pulse when the counter reaches the target while counting is enabled. Software reaches it through two write strobes. One configures the channel: the mode, and an arm bit that lets the next comparator write also move the target. The other writes the comparator value under a per-bit mask.

In one-shot mode a comparator write moves the target and nothing else. The channel then fires once when the counter reaches that value, which can take a full counter wrap if the value was already behind. In periodic mode a comparator write sets the period. It moves the target only when the arm bit is set, and the arm bit clears itself on every comparator write. After each periodic match the channel moves the target forward by whole periods until it is strictly ahead of the counter. It does this by repeated addition, one period per cycle, so no divider is needed. The readback port always shows the current target.

Top module: `cmp_timer_channel`

## Requirements
- R1: After reset the target reads 0xFFFFFFFF and `fire` is low.
- R2: `fire` goes high for exactly one cycle, one clock after the first cycle in which `counterEn` is 1 and `counterVal` equals the target. It stays low while `counterEn` is 0, and it does not repeat while the counter stays on the target.
- R3: In one-shot mode (`cfgPeriodic`=0 at the last config write), a comparator write sets the target to the merged value: bits where `wrMask` is 1 take `wrData`, and the other bits keep their old value.
- R4: In periodic mode, a comparator write merges `wrData` under `wrMask` into the period. The target takes the same merged value only if the arm bit is set; otherwise the target is unchanged.
- R5: The arm bit is cleared by every comparator write, in either mode. It is set only by a config write with `cfgArmSet`=1.
- R6: A config write that selects one-shot mode forces the period to zero.
- R7: After a periodic match with a nonzero period P and match target T, let C be the counter value one cycle after the fire pulse. The new target becomes T + ((C − T) mod 2^32 / P + 1) × P, modulo 2^32. That value lies strictly ahead of C.
- R8: In one-shot mode a target behind the counter is not corrected. No pulse occurs until the counter wraps around to it, and the target is unchanged after a match.
- R9: `rdTarget` shows the current target, never the period.
- R10: In periodic mode with a zero period, a match leaves the target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| counterVal | input | 32 | Main counter value |
| counterEn | input | 1 | Main counter is counting |
| cfgWrite | input | 1 | Config write strobe |
| cfgPeriodic | input | 1 | Mode for config write: 1 periodic, 0 one-shot |
| cfgArmSet | input | 1 | Arm bit value for config write |
| cmpWrite | input | 1 | Comparator write strobe |
| wrData | input | 32 | Comparator write data |
| wrMask | input | 32 | Per-bit write mask, 1 = update |
| rdTarget | output | 32 | Current target readback |
| fire | output | 1 | One-cycle match pulse |

## Verification
The bench aims the rounding step at counter values that are exact period multiples past the target. A design that rounds with "greater or equal" instead of "strictly ahead" would land on the counter itself at those values. The bench also runs a case that wraps past 2^32, where an unsigned-distance error would show up as a target far behind the counter. It makes a periodic write with the arm bit already consumed: a design whose arm bit does not clear would move the target, and a design that reads back the period would show the wrong value. Finally, it switches mode to one-shot and back before a match. A design that kept the old period would advance the target instead of holding it, and a design that fired on every equal cycle, or while disabled, would show extra pulses.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CATCH = 2'd1,
    ST_STEP  = 2'd2
  } adv_state_t;

  typedef struct packed {
    logic ldTgtDirect;   // one-shot comparator write
    logic ldTgtFromPer;  // armed periodic write copies into target
    logic ldPer;         // periodic comparator write into period
    logic clrPer;        // mode switched to one-shot
    logic startAdv;      // periodic match: begin rounding
    logic capGap;        // sample counter distance
    logic stepAdv;       // add one more period
    logic endAdv;        // commit rounded target
  } strobe_t;

endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      stb,
  input  logic [W-1:0] counterVal,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] wrMask,
  output logic [W-1:0] target,
  output logic         hit,
  output logic         advDone,
  output logic         perZero
);

  localparam logic [W-1:0] TARGET_RST = {W{1'b1}};

  logic [W-1:0] period;
  logic [W-1:0] base;
  logic [W-1:0] gap;
  logic [W:0]   accum;
  logic [W-1:0] tgtMerged;
  logic [W-1:0] perMerged;

  assign tgtMerged = (target & ~wrMask) | (wrData & wrMask);
  assign perMerged = (period & ~wrMask) | (wrData & wrMask);

  assign hit     = (counterVal == target);
  assign perZero = (period == '0);
  assign advDone = (accum > {1'b0, gap});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      target <= TARGET_RST;
      period <= '0;
      base   <= '0;
      gap    <= '0;
      accum  <= '0;
    end else begin
      if (stb.clrPer)      period <= '0;
      else if (stb.ldPer)  period <= perMerged;

      if (stb.ldTgtDirect)       target <= tgtMerged;
      else if (stb.ldTgtFromPer) target <= perMerged;
      else if (stb.endAdv)       target <= base + accum[W-1:0];

      if (stb.startAdv) begin
        base  <= target;
        accum <= {1'b0, period};
      end else if (stb.stepAdv) begin
        accum <= accum + {1'b0, period};
      end

      if (stb.capGap) gap <= counterVal - base;
    end
  end

  // R6: leaving periodic mode empties the period
  assert_period_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrPer |=> perZero);

  // R7: committed target is strictly past the sampled counter distance
  assert_advance_ahead_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.endAdv && !stb.ldTgtDirect && !stb.ldTgtFromPer)
      |=> ((target - $past(base)) > $past(gap)));

endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    counterEn,
  input  logic    cfgWrite,
  input  logic    cfgPeriodic,
  input  logic    cfgArmSet,
  input  logic    cmpWrite,
  input  logic    hit,
  input  logic    advDone,
  input  logic    perZero,
  output strobe_t stb,
  output logic    fire
);

  adv_state_t state, stateNext;
  logic periodicQ;
  logic armedQ;
  logic hitPrev;
  logic hitNow;
  logic anyWrite;

  assign anyWrite = cmpWrite | cfgWrite;
  assign hitNow   = (state == ST_IDLE) && counterEn && hit;

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (cmpWrite) begin
      if (periodicQ) begin
        stb.ldPer        = 1'b1;
        stb.ldTgtFromPer = armedQ;
      end else begin
        stb.ldTgtDirect = 1'b1;
      end
    end
    if (cfgWrite && !cfgPeriodic) stb.clrPer = 1'b1;

    unique case (state)
      ST_IDLE: begin
        if (hitNow && !hitPrev && periodicQ && !perZero && !anyWrite) begin
          stb.startAdv = 1'b1;
          stateNext    = ST_CATCH;
        end
      end
      ST_CATCH: begin
        stb.capGap = !anyWrite;
        stateNext  = ST_STEP;
      end
      ST_STEP: begin
        if (advDone) begin
          stb.endAdv = !anyWrite;
          stateNext  = ST_IDLE;
        end else begin
          stb.stepAdv = !anyWrite;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (anyWrite) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      periodicQ <= 1'b0;
      armedQ    <= 1'b0;
      hitPrev   <= 1'b0;
      fire      <= 1'b0;
    end else begin
      state   <= stateNext;
      hitPrev <= hitNow;
      fire    <= hitNow && !hitPrev;
      if (cfgWrite) begin
        periodicQ <= cfgPeriodic;
        armedQ    <= cfgArmSet;
      end else if (cmpWrite) begin
        armedQ <= 1'b0;
      end
    end
  end

  // R2: the pulse never lasts two cycles
  assert_fire_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> !fire);

  // R2: a pulse needs the counter enabled on the matching cycle
  assert_fire_enabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fire) |-> $past(counterEn));

  // R5: comparator write consumes the arm bit
  assert_arm_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWrite && !cfgWrite) |=> !armedQ);

  // R4: without an armed bit a periodic write leaves the target path idle
  assert_unarmed_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldPer && !armedQ) |-> !stb.ldTgtFromPer && !stb.ldTgtDirect);

endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
  import cmp_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] counterVal,
  input  logic         counterEn,
  input  logic         cfgWrite,
  input  logic         cfgPeriodic,
  input  logic         cfgArmSet,
  input  logic         cmpWrite,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] wrMask,
  output logic [W-1:0] rdTarget,
  output logic         fire
);

  strobe_t stb;
  logic    hit;
  logic    advDone;
  logic    perZero;

  cmp_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .counterEn  (counterEn),
    .cfgWrite   (cfgWrite),
    .cfgPeriodic(cfgPeriodic),
    .cfgArmSet  (cfgArmSet),
    .cmpWrite   (cmpWrite),
    .hit        (hit),
    .advDone    (advDone),
    .perZero    (perZero),
    .stb        (stb),
    .fire       (fire)
  );

  cmp_timer_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .counterVal(counterVal),
    .wrData    (wrData),
    .wrMask    (wrMask),
    .target    (rdTarget),
    .hit       (hit),
    .advDone   (advDone),
    .perZero   (perZero)
  );

endmodule

// File: tb/test_cmp_timer_channel.sv
module test_cmp_timer_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] counterVal = '0;
  logic        counterEn = 1'b0;
  logic        cfgWrite = 1'b0;
  logic        cfgPeriodic = 1'b0;
  logic        cfgArmSet = 1'b0;
  logic        cmpWrite = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] wrMask = '0;
  logic [31:0] rdTarget;
  logic        fire;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cmp_timer_channel i_cmp_timer_channel (
    .clk(clk), .rstN(rstN), .counterVal(counterVal), .counterEn(counterEn),
    .cfgWrite(cfgWrite), .cfgPeriodic(cfgPeriodic), .cfgArmSet(cfgArmSet),
    .cmpWrite(cmpWrite), .wrData(wrData), .wrMask(wrMask),
    .rdTarget(rdTarget), .fire(fire)
  );

  // columns: match target, period, counter after fire, expected new target
  localparam logic [31:0] VEC [0:4][0:3] = '{
    '{32'd1000,       32'd100, 32'd1000,       32'd1100},
    '{32'd1000,       32'd100, 32'd1350,       32'd1400},
    '{32'd1000,       32'd100, 32'd1400,       32'd1500},
    '{32'hFFFF_FFF0,  32'd16,  32'h0000_0005,  32'h0000_0010},
    '{32'd50,         32'd7,   32'd119,        32'd120}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfgWr(input bit per, input bit arm);
    cfgWrite = 1'b1; cfgPeriodic = per; cfgArmSet = arm;
    tick();
    cfgWrite = 1'b0; cfgPeriodic = 1'b0; cfgArmSet = 1'b0;
  endtask

  task automatic cmpWr(input logic [31:0] d, input logic [31:0] m);
    cmpWrite = 1'b1; wrData = d; wrMask = m;
    tick();
    cmpWrite = 1'b0; wrData = '0; wrMask = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check(rdTarget == 32'hFFFF_FFFF, "R1 target", rdTarget, 32'hFFFF_FFFF);
    check(fire == 1'b0, "R1 fire", {31'd0, fire}, 32'd0);
    rstN = 1'b1;
    tick();

    // Table: periodic rounding (R7), unarmed write (R4, R5, R9)
    counterEn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      logic [31:0] t, p, c1, ex;
      bit moved;
      t = VEC[i][0]; p = VEC[i][1]; c1 = VEC[i][2]; ex = VEC[i][3];
      counterVal = t ^ 32'h8000_0000;
      cfgWr(1'b1, 1'b1);
      cmpWr(t, 32'hFFFF_FFFF);
      check(rdTarget == t, "R4 armed write", rdTarget, t);
      cmpWr(p, 32'hFFFF_FFFF);
      check(rdTarget == t, "R5 R9 unarmed write keeps target", rdTarget, t);
      counterVal = t;
      tick();
      check(fire == 1'b1, "R2 periodic fire", {31'd0, fire}, 32'd1);
      counterVal = c1;
      tick();
      check(fire == 1'b0, "R2 pulse width", {31'd0, fire}, 32'd0);
      moved = 1'b0;
      for (int k = 0; k < 40 && !moved; k++) begin
        if (rdTarget != t) moved = 1'b1;
        else tick();
      end
      check(rdTarget == ex, "R7 rounded target", rdTarget, ex);
    end

    // R3 masked one-shot write
    counterVal = 32'd7;
    cfgWr(1'b0, 1'b0);
    cmpWr(32'h1234_5678, 32'hFFFF_FFFF);
    cmpWr(32'hABCD_0000, 32'hFFFF_0000);
    check(rdTarget == 32'hABCD_5678, "R3 masked merge", rdTarget, 32'hABCD_5678);

    // R2 disabled counter, held equality
    cmpWr(32'd500, 32'hFFFF_FFFF);
    counterEn = 1'b0;
    counterVal = 32'd500;
    tick(); tick();
    check(fire == 1'b0, "R2 disabled no fire", {31'd0, fire}, 32'd0);
    counterEn = 1'b1;
    tick();
    check(fire == 1'b1, "R2 enabled fire", {31'd0, fire}, 32'd1);
    tick();
    check(fire == 1'b0, "R2 held equal no repeat", {31'd0, fire}, 32'd0);
    tick();
    check(fire == 1'b0, "R2 held equal no repeat 2", {31'd0, fire}, 32'd0);
    check(rdTarget == 32'd500, "R8 one-shot target kept", rdTarget, 32'd500);

    // R8 target behind counter waits for wrap
    cmpWr(32'd200, 32'hFFFF_FFFF);
    counterVal = 32'd300;
    tick(); tick();
    check(fire == 1'b0, "R8 no fire behind", {31'd0, fire}, 32'd0);
    counterVal = 32'hFFFF_FFFF; tick();
    counterVal = 32'd0; tick();
    check(fire == 1'b0, "R8 no fire at wrap", {31'd0, fire}, 32'd0);
    counterVal = 32'd200; tick();
    check(fire == 1'b1, "R8 fire after wrap", {31'd0, fire}, 32'd1);
    check(rdTarget == 32'd200, "R8 target unchanged", rdTarget, 32'd200);

    // R6 / R10 mode switch clears period; periodic zero period holds target
    counterVal = 32'd10;
    cfgWr(1'b1, 1'b1);
    cmpWr(32'd3000, 32'hFFFF_FFFF);
    cfgWr(1'b0, 1'b0);
    cfgWr(1'b1, 1'b0);
    counterVal = 32'd3000;
    tick();
    check(fire == 1'b1, "R10 fire with zero period", {31'd0, fire}, 32'd1);
    counterVal = 32'd3001;
    for (int k = 0; k < 6; k++) tick();
    check(rdTarget == 32'd3000, "R6 R10 target held", rdTarget, 32'd3000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule